// File: doc/BRIEF.md
# Domain-Aware Stop Demand Filter

This block sits where a broadcast stop demand arrives at one attachment point of a partitioned multi-board system. It decides which local resources must halt so that the domain in error is frozen and no other domain is touched. One side of the block acts for the central switch. It turns the errored port number into a per-port stop vector. It uses a programmable reachability matrix and a per-port flag that marks expanders shared between domains ("split"). The other side acts for one expander, whose own port number is a parameter. It checks the errored port against two per-slot membership masks, raises a pause line to each board slot that can talk to that port, and halts its slave units. On a split expander, only the unit halves of the affected slots are halted.

Every stop, pause and halt bit is registered one cycle after the demand. It remembers the domain of the demand that first raised it, and it stays high until that domain's release line is pulsed. Configuration is a plain write port, and it is locked while anything is stopped. A demand that names a port beyond the configured count changes nothing and sets a sticky error flag.

Top module: `stop_demand_filter`

## Requirements
- R1: While and right after reset, all of port_stop_o, slot_pause_o, unit_halt_o and cfg_err_o are low.
- R2: An in-range demand for a non-split port p sets, one clock later, port_stop_o bit p and every bit q whose reachability row p has bit q set and whose split flag is clear.
- R3: An in-range demand for a port whose split flag is set stops that port only at the switch level.
- R4: slot_pause_o[s] is raised one clock after a demand for port p when bit p of slot s's membership mask is set.
- R5: When the local port's split flag is clear, both unit_halt_o bits rise together whenever any slot is paused by the demand.
- R6: When the local port's split flag is set, unit_halt_o[s] rises only together with slot_pause_o[s].
- R7: Each raised bit records the domain (dmd_dom_i) of the demand that first raised it. It falls only when release_i has that domain's bit set. A release of any other domain leaves it high.
- R8: A demand whose port number is not below NUM_PORTS changes no output except that cfg_err_o goes high and stays high until reset.
- R9: Write addresses: 0..NUM_PORTS-1 select a reachability row, NUM_PORTS the split flags (bit per port), NUM_PORTS+1 and NUM_PORTS+2 the membership masks of slot 0 and slot 1. A write is dropped while any stop, pause or halt output is high.
- R10: Demands accumulate. A later demand adds bits and never clears bits that are already high, nor changes their owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(NUM_PORTS+3) | Configuration register select |
| cfg_wdata_i | input | NUM_PORTS | Configuration write data |
| dmd_valid_i | input | 1 | Stop demand present this cycle |
| dmd_port_i | input | PID_W | Port in error |
| dmd_dom_i | input | $clog2(NUM_DOMAINS) | Domain that issued the demand |
| release_i | input | NUM_DOMAINS | Per-domain release pulse |
| port_stop_o | output | NUM_PORTS | Switch-level stop per port |
| slot_pause_o | output | 2 | Pause line per local board slot |
| unit_halt_o | output | 2 | Halt of each half of the local slave units |
| cfg_err_o | output | 1 | Sticky out-of-range demand flag |

## Verification
Demands are issued for a non-split port with a wide reachability row, for a split port, and for a port named only in the second slot's mask. This separates the switch-level fan-out from the self-only stop, and the slot selection from the halt width. The same slot demand is repeated after the local port is marked split, which distinguishes whole-unit halting from per-half halting. Overlapping demands from two domains are released one domain at a time, so that owner tracking is seen to differ from a plain OR. Out-of-range demands and writes made while stopped must leave every output unchanged.

// File: rtl/stop_filter_pkg.sv
package stop_filter_pkg;
  localparam int unsigned NUM_SLOTS = 2;

  function automatic logic [NUM_SLOTS-1:0] halt_pattern(input logic split,
                                                        input logic [NUM_SLOTS-1:0] pause);
    return split ? pause : {NUM_SLOTS{|pause}};
  endfunction
endpackage

// File: rtl/sf_cfg_regs.sv
module sf_cfg_regs #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic                                 lock_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [NUM_PORTS-1:0]                 wdata_i,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  reach_o,
  output logic [NUM_PORTS-1:0]                 split_o,
  output logic [1:0][NUM_PORTS-1:0]            mask_o
);
  localparam int unsigned SPLIT_A = NUM_PORTS;
  localparam int unsigned MASK_A  = NUM_PORTS + 1;

  logic wr;
  assign wr = we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reach_o <= '0;
      split_o <= '0;
      mask_o  <= '0;
    end else if (wr) begin
      for (int r = 0; r < int'(NUM_PORTS); r++)
        if (addr_i == ADDR_W'(r)) reach_o[r] <= wdata_i;
      if (addr_i == ADDR_W'(SPLIT_A)) split_o <= wdata_i;
      for (int s = 0; s < 2; s++)
        if (addr_i == ADDR_W'(MASK_A + s)) mask_o[s] <= wdata_i;
    end
  end
endmodule

// File: rtl/sf_switch_decode.sv
module sf_switch_decode #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PW        = 3
) (
  input  logic [PW-1:0]                        port_i,
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  reach_i,
  input  logic [NUM_PORTS-1:0]                 split_i,
  output logic [NUM_PORTS-1:0]                 stop_o
);
  always_comb begin
    stop_o = '0;
    stop_o[port_i] = 1'b1;
    // a shared expander is stopped alone; its own concentrator handles the rest
    if (!split_i[port_i]) stop_o = stop_o | (reach_i[port_i] & ~split_i);
  end
endmodule

// File: rtl/sf_expander_decode.sv
module sf_expander_decode
  import stop_filter_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 8,
  parameter int unsigned PW         = 3,
  parameter int unsigned LOCAL_PORT = 3
) (
  input  logic [PW-1:0]                 port_i,
  input  logic [1:0][NUM_PORTS-1:0]     mask_i,
  input  logic [NUM_PORTS-1:0]          split_i,
  output logic [NUM_SLOTS-1:0]          pause_o,
  output logic [NUM_SLOTS-1:0]          halt_o
);
  logic [NUM_SLOTS-1:0] pause_w;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign pause_w[s] = mask_i[s][port_i];
  end

  assign pause_o = pause_w;
  assign halt_o  = halt_pattern(split_i[LOCAL_PORT], pause_w);
endmodule

// File: rtl/sf_stop_hold.sv
module sf_stop_hold #(
  parameter int unsigned W  = 8,
  parameter int unsigned ND = 4,
  parameter int unsigned DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  set_i,
  input  logic [DW-1:0] dom_i,
  input  logic [ND-1:0] rel_i,
  output logic [W-1:0]  act_o
);
  logic [W-1:0]         act_q, act_d, clr;
  logic [W-1:0][DW-1:0] own_q, own_d;

  always_comb begin
    act_d = act_q;
    own_d = own_q;
    clr   = '0;
    for (int b = 0; b < int'(W); b++) begin
      clr[b] = act_q[b] && rel_i[own_q[b]];
      if (set_i[b] && (!act_q[b] || clr[b])) begin
        act_d[b] = 1'b1;
        own_d[b] = dom_i;
      end else if (clr[b]) begin
        act_d[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      own_q <= '0;
    end else begin
      act_q <= act_d;
      own_q <= own_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/stop_demand_filter.sv
module stop_demand_filter
  import stop_filter_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned NUM_DOMAINS = 4,
  parameter int unsigned PID_W       = 4,
  parameter int unsigned LOCAL_PORT  = 3,
  localparam int unsigned ADDR_W     = $clog2(NUM_PORTS + 3),
  localparam int unsigned DW         = $clog2(NUM_DOMAINS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [ADDR_W-1:0]      cfg_addr_i,
  input  logic [NUM_PORTS-1:0]   cfg_wdata_i,
  input  logic                   dmd_valid_i,
  input  logic [PID_W-1:0]       dmd_port_i,
  input  logic [DW-1:0]          dmd_dom_i,
  input  logic [NUM_DOMAINS-1:0] release_i,
  output logic [NUM_PORTS-1:0]   port_stop_o,
  output logic [1:0]             slot_pause_o,
  output logic [1:0]             unit_halt_o,
  output logic                   cfg_err_o
);
  localparam int unsigned PW = $clog2(NUM_PORTS);

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] reach_w;
  logic [NUM_PORTS-1:0]                split_w;
  logic [1:0][NUM_PORTS-1:0]           mask_w;
  logic [NUM_PORTS-1:0]                sw_stop;
  logic [NUM_SLOTS-1:0]                ex_pause, ex_halt;
  logic [2*NUM_SLOTS-1:0]              ex_act;
  logic                                in_range, hit, lock, cfg_err_q;
  logic [PW-1:0]                       port_idx;

  assign in_range = dmd_port_i < PID_W'(NUM_PORTS);
  assign hit      = dmd_valid_i && in_range;
  assign port_idx = dmd_port_i[PW-1:0];
  assign lock     = |port_stop_o || |slot_pause_o || |unit_halt_o;

  sf_cfg_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .lock_i(lock), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .reach_o(reach_w), .split_o(split_w), .mask_o(mask_w)
  );

  sf_switch_decode #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_sw (
    .port_i(port_idx), .reach_i(reach_w), .split_i(split_w), .stop_o(sw_stop)
  );

  sf_expander_decode #(.NUM_PORTS(NUM_PORTS), .PW(PW), .LOCAL_PORT(LOCAL_PORT)) u_ex (
    .port_i(port_idx), .mask_i(mask_w), .split_i(split_w),
    .pause_o(ex_pause), .halt_o(ex_halt)
  );

  sf_stop_hold #(.W(NUM_PORTS), .ND(NUM_DOMAINS), .DW(DW)) u_port_hold (
    .clk_i, .rst_ni, .set_i(hit ? sw_stop : '0), .dom_i(dmd_dom_i),
    .rel_i(release_i), .act_o(port_stop_o)
  );

  sf_stop_hold #(.W(2*NUM_SLOTS), .ND(NUM_DOMAINS), .DW(DW)) u_slot_hold (
    .clk_i, .rst_ni, .set_i(hit ? {ex_halt, ex_pause} : '0), .dom_i(dmd_dom_i),
    .rel_i(release_i), .act_o(ex_act)
  );

  assign slot_pause_o = ex_act[NUM_SLOTS-1:0];
  assign unit_halt_o  = ex_act[2*NUM_SLOTS-1:NUM_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cfg_err_q <= 1'b0;
    else if (dmd_valid_i && !in_range)   cfg_err_q <= 1'b1;
  end
  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned NUM_DOMAINS = 4,
  parameter int unsigned PID_W       = 4,
  parameter int unsigned LOCAL_PORT  = 3
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                cfg_we_i,
  input logic                                dmd_valid_i,
  input logic [PID_W-1:0]                    dmd_port_i,
  input logic [NUM_DOMAINS-1:0]              release_i,
  input logic [NUM_PORTS-1:0]                port_stop_o,
  input logic [1:0]                          slot_pause_o,
  input logic [1:0]                          unit_halt_o,
  input logic                                cfg_err_o,
  input logic [NUM_PORTS-1:0][NUM_PORTS-1:0] reach_i,
  input logic [NUM_PORTS-1:0]                split_i,
  input logic [1:0][NUM_PORTS-1:0]           mask_i
);
  localparam int unsigned PW = $clog2(NUM_PORTS);

  logic ok_port, busy;
  assign ok_port = dmd_valid_i && (dmd_port_i < PID_W'(NUM_PORTS));
  assign busy    = |port_stop_o || |slot_pause_o || |unit_halt_o;

  a_r2_errored_port_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_port |=> port_stop_o[$past(dmd_port_i[PW-1:0])]);

  a_r3_split_stops_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_port && split_i[dmd_port_i[PW-1:0]] && port_stop_o == '0 && release_i == '0
    |=> $countones(port_stop_o) == 1);

  a_r6_split_half_follows_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_i[LOCAL_PORT] |-> unit_halt_o == slot_pause_o);

  a_r7_no_drop_without_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i == '0 |=> (port_stop_o & $past(port_stop_o)) == $past(port_stop_o)
                        && (slot_pause_o & $past(slot_pause_o)) == $past(slot_pause_o));

  a_r8_out_of_range_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmd_valid_i && !ok_port && release_i == '0
    |=> $stable(port_stop_o) && $stable(slot_pause_o) && $stable(unit_halt_o));

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  a_r9_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && busy |=> $stable(reach_i) && $stable(split_i) && $stable(mask_i));
endmodule

bind stop_demand_filter sf_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_DOMAINS(NUM_DOMAINS), .PID_W(PID_W), .LOCAL_PORT(LOCAL_PORT)
) u_sf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .dmd_valid_i(dmd_valid_i),
  .dmd_port_i(dmd_port_i), .release_i(release_i), .port_stop_o(port_stop_o),
  .slot_pause_o(slot_pause_o), .unit_halt_o(unit_halt_o), .cfg_err_o(cfg_err_o),
  .reach_i(reach_w), .split_i(split_w), .mask_i(mask_w)
);

// File: tb/tb_stop_demand_filter.sv
module tb_stop_demand_filter;
  localparam int N = 8;
  localparam int ND = 4;
  localparam int LP = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_addr_i = '0;
  logic [N-1:0] cfg_wdata_i = '0;
  logic dmd_valid_i = 1'b0;
  logic [3:0] dmd_port_i = '0;
  logic [1:0] dmd_dom_i = '0;
  logic [ND-1:0] release_i = '0;
  logic [N-1:0] port_stop_o;
  logic [1:0] slot_pause_o, unit_halt_o;
  logic cfg_err_o;

  always #5 clk_i = ~clk_i;

  stop_demand_filter dut (.*);

  typedef struct {
    logic [N-1:0] ps;
    logic [1:0]   pa;
    logic [1:0]   ha;
    logic         er;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // requirement-level model state
  logic [N-1:0] m_reach [N];
  logic [N-1:0] m_split;
  logic [N-1:0] m_mask [2];
  logic [N-1:0] m_ps;
  int           m_pown [N];
  logic [3:0]   m_sl;      // {halt, pause}
  int           m_sown [4];
  logic         m_err;

  function automatic bit m_locked();
    return (m_ps != '0) || (m_sl != '0);
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.ps = m_ps; e.pa = m_sl[1:0]; e.ha = m_sl[3:2]; e.er = m_err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle_in();
    cfg_we_i = 1'b0; dmd_valid_i = 1'b0; release_i = '0;
  endtask

  task automatic do_cfg(int addr, logic [N-1:0] data, string tag);
    @(negedge clk_i);
    idle_in();
    cfg_we_i = 1'b1; cfg_addr_i = 4'(addr); cfg_wdata_i = data;
    if (!m_locked()) begin
      if (addr < N) m_reach[addr] = data;
      else if (addr == N) m_split = data;
      else if (addr <= N + 2) m_mask[addr-N-1] = data;
    end
    @(posedge clk_i);
    push(tag);
  endtask

  task automatic do_dmd(int p, int d, string tag);
    logic [N-1:0] sv;
    logic [1:0] pa, ha;
    logic [3:0] nv;
    @(negedge clk_i);
    idle_in();
    dmd_valid_i = 1'b1; dmd_port_i = 4'(p); dmd_dom_i = 2'(d);
    if (p >= N) m_err = 1'b1;
    else begin
      sv = '0; sv[p] = 1'b1;
      if (!m_split[p]) sv = sv | (m_reach[p] & ~m_split);
      for (int b = 0; b < N; b++)
        if (sv[b] && !m_ps[b]) begin m_ps[b] = 1'b1; m_pown[b] = d; end
      pa[0] = m_mask[0][p]; pa[1] = m_mask[1][p];
      ha = m_split[LP] ? pa : {2{|pa}};
      nv = {ha, pa};
      for (int b = 0; b < 4; b++)
        if (nv[b] && !m_sl[b]) begin m_sl[b] = 1'b1; m_sown[b] = d; end
    end
    @(posedge clk_i);
    push(tag);
  endtask

  task automatic do_rel(logic [ND-1:0] mask, string tag);
    @(negedge clk_i);
    idle_in();
    release_i = mask;
    for (int b = 0; b < N; b++) if (m_ps[b] && mask[m_pown[b]]) m_ps[b] = 1'b0;
    for (int b = 0; b < 4; b++) if (m_sl[b] && mask[m_sown[b]]) m_sl[b] = 1'b0;
    @(posedge clk_i);
    push(tag);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk_i);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (port_stop_o !== e.ps || slot_pause_o !== e.pa ||
            unit_halt_o !== e.ha || cfg_err_o !== e.er) begin
          errors++;
          $display("FAIL %s: actual stop=%b pause=%b halt=%b err=%b expected stop=%b pause=%b halt=%b err=%b",
                   e.tag, port_stop_o, slot_pause_o, unit_halt_o, cfg_err_o,
                   e.ps, e.pa, e.ha, e.er);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_reach[i] = '0; m_pown[i] = 0; end
    for (int i = 0; i < 4; i++) m_sown[i] = 0;
    m_split = '0; m_mask[0] = '0; m_mask[1] = '0; m_ps = '0; m_sl = '0; m_err = 1'b0;

    @(posedge clk_i);
    push("R1 outputs low in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i);
    push("R1 outputs low after reset");

    do_cfg(2,     8'b1011_0110, "R9 write reach row 2");
    do_cfg(N,     8'b0010_0000, "R9 write split flags");
    do_cfg(N + 1, 8'b0000_0100, "R9 write slot0 mask");
    do_cfg(N + 2, 8'b1000_0000, "R9 write slot1 mask");

    do_dmd(2, 1, "R2 R4 R5 nonsplit port fan-out");
    do_cfg(N, 8'hFF, "R9 split write while stopped dropped");
    do_rel(4'b0001, "R7 foreign release no effect");
    do_rel(4'b0010, "R7 owner release clears");
    do_dmd(2, 1, "R9 config unchanged after locked write");
    do_rel(4'b0010, "R7 clear again");

    do_dmd(5, 2, "R3 split port stops itself only");
    do_rel(4'b0100, "R7 release split stop");

    do_dmd(9, 0, "R8 out-of-range ignored, flag set");
    do_dmd(15, 1, "R8 flag sticky, still ignored");

    do_dmd(7, 0, "R4 R5 slot1 pause and full halt");
    do_dmd(2, 1, "R10 second demand accumulates");
    do_rel(4'b0001, "R7 R10 first owner released, second kept");
    do_rel(4'b0010, "R7 remaining cleared");

    do_cfg(N, 8'b0010_1000, "R9 mark local port split");
    do_dmd(7, 1, "R6 split local halts slot1 half only");
    do_rel(4'b0010, "R7 split local release");
    do_dmd(2, 3, "R6 split local halts slot0 half only");
    do_rel(4'b1000, "R7 final release");

    @(negedge clk_i); idle_in();
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule